// File: doc/BRIEF.md
# Decimal Adjust Unit

This block repairs an 8-bit accumulator after a binary add or subtract of two packed-BCD bytes, so that the result again holds two valid decimal digits. It takes the accumulator together with the half-carry, carry and subtract flags left by the previous arithmetic operation. It returns the corrected byte and a fresh set of sign, zero, half-carry, parity and carry flags. The subtract flag is passed through untouched.

A correction byte is built from two parts. A low part of 0x06 repairs the units digit. A high part of 0x60 repairs the tens digit. The decision on the high part uses a threshold that moves with the units digit. After a subtraction the correction is negated and then added, so one adder serves both directions.

The datapath is purely combinational. A parameter chooses between a combinational output and an output register that loads under an enable.

Top module: `dec_adjust_unit`

## Requirements
- R1: The correction byte has 0x06 in its low part when the accumulator's low nibble (bits 3:0) is 0xA or greater, or when the half-carry input is 1; otherwise its low part is 0x0.
- R2: The correction gains 0x60 when the carry input is 1, or when the whole accumulator is at or above a threshold. The threshold is 0x90 if the low nibble is 0xA or greater, and 0xA0 otherwise.
- R3: The carry output is 1 whenever the 0x60 part is applied; otherwise it equals the carry input.
- R4: With the subtract input at 0 the adjusted byte is accumulator plus correction, modulo 256. With it at 1 the adjusted byte is accumulator minus correction, modulo 256.
- R5: The sign output equals bit 7 of the adjusted byte. The zero output is 1 exactly when the adjusted byte is 0x00.
- R6: The parity output is 1 when the adjusted byte has an even number of 1 bits.
- R7: The half-carry output equals bit 4 of (input accumulator XOR adjusted byte).
- R8: The subtract output equals the subtract input.
- R9: With REG_OUT=1 every output is 0 after reset. The outputs take the new values on the rising clock edge where the enable is 1. They hold their values across edges where the enable is 0.
- R10: With REG_OUT=0 the outputs follow the inputs combinationally, and the clock, reset and enable have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| en | input | 1 | Load enable of the output register |
| acc_in | input | 8 | Accumulator before adjustment |
| h_in | input | 1 | Half-carry flag from the previous operation |
| c_in | input | 1 | Carry flag from the previous operation |
| n_in | input | 1 | Subtract flag from the previous operation |
| acc_out | output | 8 | Adjusted accumulator |
| s_out | output | 1 | Sign flag of the result |
| z_out | output | 1 | Zero flag of the result |
| h_out | output | 1 | Recomputed half-carry flag |
| pv_out | output | 1 | Even-parity flag of the result |
| n_out | output | 1 | Subtract flag, passed through |
| c_out | output | 1 | Updated carry flag |

## Verification
The bench builds two instances from the same inputs. One uses REG_OUT=1, the default, which brings the enable-gated load and hold and the reset values within reach. The other uses REG_OUT=0 and checks that the same results appear without a clock edge. Both instances see every accumulator value under all eight flag combinations, so both threshold values, the carry-forced and carry-kept paths, and the negated correction are all reached. Random vectors and directed byte values close to the 0x90 and 0xA0 thresholds are added on top.

// File: rtl/dau_pkg.sv
package dau_pkg;
   localparam int unsigned DIGIT_W = 4;
   localparam int unsigned DIGITS  = 2;
   localparam int unsigned ACC_W   = DIGIT_W * DIGITS;
   localparam int unsigned OUT_W   = ACC_W + 6;

   localparam logic [DIGIT_W-1:0] DIGIT_LIMIT = 4'hA;
   localparam logic [DIGIT_W-1:0] DIGIT_FIX   = 4'h6;
   localparam logic [ACC_W-1:0]   THR_LOW_BIG = 8'h90;
   localparam logic [ACC_W-1:0]   THR_LOW_OK  = 8'hA0;

   typedef struct packed {
      logic s;
      logic z;
      logic h;
      logic pv;
      logic n;
      logic c;
   } dau_flags_t;

   function automatic logic even_ones(input logic [ACC_W-1:0] v);
      logic p;
      p = 1'b1;
      for (int i = 0; i < ACC_W; i++) p = p ^ v[i];
      return p;
   endfunction
endpackage

// File: rtl/dau_corr.sv
module dau_corr
   import dau_pkg::*;
(
   input  logic [ACC_W-1:0] acc,
   input  logic             h_flag,
   input  logic             c_flag,
   output logic [ACC_W-1:0] corr,
   output logic             hi_applied
);
   logic             lo_big;
   logic             lo_need;
   logic [ACC_W-1:0] thr;

   always_comb begin
      lo_big     = (acc[DIGIT_W-1:0] >= DIGIT_LIMIT);
      lo_need    = lo_big | h_flag;
      thr        = lo_big ? THR_LOW_BIG : THR_LOW_OK;
      hi_applied = c_flag | (acc >= thr);
      corr       = '0;
      if (lo_need)    corr[DIGIT_W-1:0]       = DIGIT_FIX;
      if (hi_applied) corr[ACC_W-1:DIGIT_W]   = DIGIT_FIX;
   end

   always_comb begin
      AST_CORR_SHAPE: assert ((corr & 8'h99) == 8'h00); // R1
      if (h_flag) AST_H_FORCES_LO: assert (corr[DIGIT_W-1:0] == DIGIT_FIX); // R1
      if (acc >= THR_LOW_OK) AST_TOP_FORCES_HI: assert (hi_applied); // R2
   end
endmodule

// File: rtl/dau_apply.sv
module dau_apply
   import dau_pkg::*;
(
   input  logic [ACC_W-1:0] acc,
   input  logic [ACC_W-1:0] corr,
   input  logic             n_flag,
   output logic [ACC_W-1:0] result,
   output logic             s_flag,
   output logic             z_flag,
   output logic             h_flag,
   output logic             pv_flag
);
   logic [ACC_W-1:0] addend;

   always_comb begin
      addend  = n_flag ? (~corr + 1'b1) : corr;
      result  = acc + addend;
      s_flag  = result[ACC_W-1];
      z_flag  = (result == '0);
      h_flag  = acc[DIGIT_W] ^ result[DIGIT_W];
      pv_flag = even_ones(result);
   end

   always_comb begin
      if (corr == '0) AST_NO_CORR_IDENTITY: assert (result == acc); // R4
      if (!n_flag && corr[DIGIT_W-1:0] == '0)
         AST_ADD_LOW_KEPT: assert (result[DIGIT_W-1:0] == acc[DIGIT_W-1:0]); // R4
   end
endmodule

// File: rtl/dau_outreg.sv
module dau_outreg #(
   parameter int unsigned W       = 14,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (REG_OUT) begin : g_reg
         logic [W-1:0] q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q_r <= '0;
            else if (en) q_r <= d;
         end
         assign q = q_r;

         AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> $stable(q)); // R9
         AST_LOAD_WHEN_EN: assert property (@(posedge clk) disable iff (!rst_n)
            en |=> (q == $past(d))); // R9
      end else begin : g_comb
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/dec_adjust_unit.sv
module dec_adjust_unit
   import dau_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [ACC_W-1:0] acc_in,
   input  logic             h_in,
   input  logic             c_in,
   input  logic             n_in,
   output logic [ACC_W-1:0] acc_out,
   output logic             s_out,
   output logic             z_out,
   output logic             h_out,
   output logic             pv_out,
   output logic             n_out,
   output logic             c_out
);
   generate
      if (DIGIT_W != 4 || DIGITS != 2) begin : g_bad_size
         $error("decimal adjust rules are defined for two 4-bit digits");
      end
   endgenerate

   logic [ACC_W-1:0] corr;
   logic             hi_applied;
   logic [ACC_W-1:0] result;
   dau_flags_t       fl;
   logic [OUT_W-1:0] pack_d;
   logic [OUT_W-1:0] pack_q;

   dau_corr u_corr (
      .acc        (acc_in),
      .h_flag     (h_in),
      .c_flag     (c_in),
      .corr       (corr),
      .hi_applied (hi_applied)
   );

   dau_apply u_apply (
      .acc     (acc_in),
      .corr    (corr),
      .n_flag  (n_in),
      .result  (result),
      .s_flag  (fl.s),
      .z_flag  (fl.z),
      .h_flag  (fl.h),
      .pv_flag (fl.pv)
   );

   assign fl.n = n_in;
   assign fl.c = hi_applied | c_in;

   assign pack_d = {result, fl};

   dau_outreg #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .d     (pack_d),
      .q     (pack_q)
   );

   assign acc_out = pack_q[OUT_W-1:6];
   assign s_out   = pack_q[5];
   assign z_out   = pack_q[4];
   assign h_out   = pack_q[3];
   assign pv_out  = pack_q[2];
   assign n_out   = pack_q[1];
   assign c_out   = pack_q[0];

   always_comb begin
      if (c_in) AST_CARRY_KEPT: assert (fl.c); // R3
      if (corr[ACC_W-1:DIGIT_W] != '0) AST_CARRY_FORCED: assert (fl.c); // R3
      AST_SIGN_FROM_RESULT: assert (fl.s == result[ACC_W-1]); // R5
   end
endmodule

// File: tb/dec_adjust_unit_tb.sv
module dec_adjust_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [7:0] acc_in = 8'h00;
   logic       h_in = 1'b0;
   logic       c_in = 1'b0;
   logic       n_in = 1'b0;

   logic [7:0] r_acc, k_acc;
   logic       r_s, r_z, r_h, r_pv, r_n, r_c;
   logic       k_s, k_z, k_h, k_pv, k_n, k_c;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   dec_adjust_unit #(.REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .acc_in(acc_in), .h_in(h_in),
      .c_in(c_in), .n_in(n_in), .acc_out(r_acc), .s_out(r_s), .z_out(r_z),
      .h_out(r_h), .pv_out(r_pv), .n_out(r_n), .c_out(r_c));

   dec_adjust_unit #(.REG_OUT(1'b0)) u_dut_comb (
      .clk(clk), .rst_n(rst_n), .en(en), .acc_in(acc_in), .h_in(h_in),
      .c_in(c_in), .n_in(n_in), .acc_out(k_acc), .s_out(k_s), .z_out(k_z),
      .h_out(k_h), .pv_out(k_pv), .n_out(k_n), .c_out(k_c));

   // expected results: {acc[7:0], s, z, h, pv, n, c}
   function automatic logic [13:0] model(input int a, input bit h, input bit c, input bit n);
      int  fix, res, ones;
      bit  hi, lo_big, cc;
      lo_big = (a % 16) > 9;
      fix = (lo_big || h) ? 6 : 0;
      hi = c || (a >= (lo_big ? 144 : 160));
      if (hi) fix = fix + 96;
      cc = hi ? 1'b1 : c;
      res = n ? (a - fix + 256) % 256 : (a + fix) % 256;
      ones = 0;
      for (int b = 0; b < 8; b++) ones += (res >> b) & 1;
      return {res[7:0], res[7], res == 0, ((a ^ res) >> 4) & 1 ? 1'b1 : 1'b0,
              (ones % 2) == 0, n, cc};
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (acc_in=0x%02h h=%0b c=%0b n=%0b)",
                  tag, act, exp, acc_in, h_in, c_in, n_in);
      end
   endtask

   task automatic chk_all(input string who, input logic [13:0] got, input logic [13:0] e);
      string acc_tag;
      acc_tag = n_in ? "R4" : ((e[0] && !c_in) ? "R2" : "R1");
      chk({who, " acc ", acc_tag}, got[13:6], e[13:6]);
      chk({who, " sign/zero R5"}, got[5:4], e[5:4]);
      chk({who, " half R7"}, got[3], e[3]);
      chk({who, " parity R6"}, got[2], e[2]);
      chk({who, " sub R8"}, got[1], e[1]);
      chk({who, " carry R3"}, got[0], e[0]);
   endtask

   task automatic run_vec(input logic [7:0] a, input bit h, input bit c, input bit n);
      logic [13:0] e;
      @(negedge clk);
      acc_in = a; h_in = h; c_in = c; n_in = n; en = 1'b1;
      e = model(a, h, c, n);
      #1;
      chk_all("comb R10", {k_acc, k_s, k_z, k_h, k_pv, k_n, k_c}, e);
      @(posedge clk);
      #1;
      chk_all("reg R9", {r_acc, r_s, r_z, r_h, r_pv, r_n, r_c}, e);
   endtask

   initial begin
      int unsigned rv;
      logic [13:0] held;
      rv = $urandom(32'd20240611);
      // reset state R9
      #20;
      chk("reset R9", {r_acc, r_s, r_z, r_h, r_pv, r_n, r_c}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // directed: 0x9A -> corr 0x66, result 0x00
      run_vec(8'h9A, 1'b0, 1'b0, 1'b0);
      chk("directed acc R2", r_acc, 8'h00);
      chk("directed carry R3", r_c, 1);
      chk("directed zero R5", r_z, 1);
      chk("directed half R7", r_h, 1);
      chk("directed parity R6", r_pv, 1);
      // threshold corners R2
      run_vec(8'h99, 1'b0, 1'b0, 1'b0);
      chk("below 0xA0 R2", r_c, 0);
      run_vec(8'hA0, 1'b0, 1'b0, 1'b0);
      chk("at 0xA0 R2", r_acc, 8'h00);
      run_vec(8'h8F, 1'b0, 1'b0, 1'b0);
      chk("below 0x90 R2", r_acc, 8'h95);
      run_vec(8'h66, 1'b0, 1'b0, 1'b1);
      chk("sub no fix R4", r_acc, 8'h66);

      // exhaustive sweep
      for (int f = 0; f < 8; f++)
         for (int a = 0; a < 256; a++)
            run_vec(a[7:0], f[2], f[1], f[0]);

      // random
      for (int i = 0; i < 300; i++) begin
         rv = $urandom;
         run_vec(rv[7:0], rv[8], rv[9], rv[10]);
      end

      // hold with enable low R9
      run_vec(8'h15, 1'b1, 1'b0, 1'b0);
      held = {r_acc, r_s, r_z, r_h, r_pv, r_n, r_c};
      @(negedge clk);
      en = 1'b0; acc_in = 8'hFF; c_in = 1'b1; n_in = 1'b1;
      @(posedge clk);
      #1;
      chk("hold R9", {r_acc, r_s, r_z, r_h, r_pv, r_n, r_c}, held);
      chk("comb ignores en R10", {k_acc, k_s, k_z, k_h, k_pv, k_n, k_c},
          model(255, 1'b1, 1'b1, 1'b1));

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1000000;
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule